// File: doc/BRIEF.md
# Bridge I/O Window Register and Decoder

This block keeps the 16-bit I/O base/limit configuration register of a root-port bridge and uses it to decide whether an incoming I/O request should be sent on to the secondary side. Software programs a 4 KB-aligned window through a small configuration port: a byte offset, two byte enables and 16 bits of write data. The port also reads the register back without delay. The decoder compares each request address with the window and reports its decision one clock later.

Only 16-bit I/O addressing is supported. The two capability nibbles are fixed at zero. The base is padded below bit 12 with zeros and the limit with ones, so the window always covers whole 4 KB pages. A parameter selects how the comparison is built: either as full 16-bit magnitude compares against the padded bounds, or as 4-bit compares on the page number alone. Both give the same decisions.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the register reads 0000h and io_fwd_valid and io_fwd are low.
- R2: The register answers at configuration byte offset 1Ch; cfg_addr bit 0 is ignored, so 1Dh selects it too. At any other offset, cfg_rdata reads 0000h and writes change nothing.
- R3: Register bits 7:4 hold the window base page (address bits 15:12) and bits 15:12 hold the window limit page; both are writable and read back as written.
- R4: cfg_be bit 0 enables register bits 7:0 and cfg_be bit 1 enables bits 15:8; a lane whose enable is low keeps its value during a write.
- R5: Register bits 3:0 and 11:8 always read 0, whatever is written to them.
- R6: A request is forwarded when {base,000h} <= req_addr[15:0] <= {limit,FFFh}, with both ends inclusive (so the reset value opens 0000h to 0FFFh).
- R7: When base is greater than limit, no request is forwarded.
- R8: A request whose req_addr has any bit above bit 15 set is never forwarded.
- R9: io_fwd_valid is high exactly one clock after req_valid was high, and io_fwd then carries that request's decision; io_fwd is low whenever io_fwd_valid is low.
- R10: A request is decided against the register value held before any configuration write in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_be | input | 2 | Byte enables for the write data |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read data for cfg_addr, without delay |
| req_valid | input | 1 | I/O request address is valid |
| req_addr | input | 32 | I/O request address |
| io_fwd_valid | output | 1 | A decision is presented |
| io_fwd | output | 1 | Forward the presented request to the secondary side |

## Verification
The assertions assume that cfg_wr, cfg_be and req_valid are known (never X) after reset and change only away from the rising clock edge. They also assume that writes are single-cycle strobes, each judged by its own cycle. The bench drives every input on the falling edge and holds it through the next rising edge. It issues requests both on their own and in the same cycle as a configuration write, so that the stable-lane and registered-decision properties are tested while the register is changing.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

   // Writable page fields of the window register
   typedef struct packed {
      logic [3:0] lim_page;
      logic [3:0] base_page;
   } win_cfg_t;

   // Register image: limit page in the top nibble, base page in bits 7:4,
   // capability nibbles fixed at zero
   function automatic logic [15:0] reg_image(input win_cfg_t c);
      return {c.lim_page, 4'h0, c.base_page, 4'h0};
   endfunction

endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs
   import iowin_pkg::*;
#(
   parameter int                    CFG_ADDR_W = 8,
   parameter logic [CFG_ADDR_W-1:0] REG_OFFSET = 8'h1C,
   parameter int                    LANES      = 2,
   parameter int                    PAGE_W     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [CFG_ADDR_W-1:0]   cfg_addr,
   input  logic [LANES-1:0]        cfg_be,
   input  logic [LANES*8-1:0]      cfg_wdata,
   output logic [LANES*8-1:0]      cfg_rdata,
   output win_cfg_t                cfg_q
);

   localparam int DATA_W = LANES * 8;
   localparam int LO_W   = 8 - PAGE_W;

   generate
      if (LANES != 2) begin : g_bad_lanes
         $error("iowin_cfg_regs: the window register spans exactly two byte lanes");
      end
      if (PAGE_W != 4) begin : g_bad_page
         $error("iowin_cfg_regs: page field must be one nibble wide");
      end
      if (CFG_ADDR_W < 2) begin : g_bad_addr
         $error("iowin_cfg_regs: configuration offset too narrow");
      end
   endgenerate

   logic                      hit;
   logic [LANES-1:0][PAGE_W-1:0] page_q;
   logic [DATA_W-1:0]         image;

   // Word select: the lane offset bit is not part of the match
   assign hit = (cfg_addr[CFG_ADDR_W-1:1] == REG_OFFSET[CFG_ADDR_W-1:1]);

   // One writable page nibble per byte lane, in the upper half of the byte
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               page_q[ln] <= '0;
            end else if (cfg_wr && hit && cfg_be[ln]) begin
               page_q[ln] <= cfg_wdata[ln*8+LO_W +: PAGE_W];
            end
         end
         assign image[ln*8 +: LO_W]          = '0;
         assign image[ln*8+LO_W +: PAGE_W]   = page_q[ln];
      end
   endgenerate

   assign cfg_q.base_page = page_q[0];
   assign cfg_q.lim_page  = page_q[1];
   assign cfg_rdata       = hit ? image : '0;

   // R4: a lane without its enable stays put
   a_r4_base_lane_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && hit && cfg_be[0]) |=> $stable(cfg_q.base_page));
   a_r4_limit_lane_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && hit && cfg_be[1]) |=> $stable(cfg_q.lim_page));
   // R5: capability nibbles read as zero
   a_r5_cap_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[11:8] == 4'h0) && (cfg_rdata[3:0] == 4'h0));
   // R2: a miss reads zero
   a_r2_miss_reads_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (cfg_rdata == '0));

endmodule

// File: rtl/iowin_bounds.sv
module iowin_bounds
   import iowin_pkg::*;
#(
   parameter int WIN_W  = 16,
   parameter int GRAN_W = 12
) (
   input  win_cfg_t          cfg_q,
   output logic [WIN_W-1:0]  eff_base,
   output logic [WIN_W-1:0]  eff_lim,
   output logic              closed
);

   localparam int PAGE_W = WIN_W - GRAN_W;

   generate
      if (PAGE_W != 4) begin : g_bad_split
         $error("iowin_bounds: window must split into a 4-bit page and offset");
      end
   endgenerate

   // Base pads the page offset with zeros, limit with ones
   assign eff_base = {cfg_q.base_page, {GRAN_W{1'b0}}};
   assign eff_lim  = {cfg_q.lim_page,  {GRAN_W{1'b1}}};
   assign closed   = (cfg_q.base_page > cfg_q.lim_page);

endmodule

// File: rtl/iowin_match.sv
module iowin_match
   import iowin_pkg::*;
#(
   parameter int REQ_W    = 32,
   parameter int WIN_W    = 16,
   parameter int GRAN_W   = 12,
   parameter bit FULL_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [REQ_W-1:0]  req_addr,
   input  win_cfg_t          cfg_q,
   input  logic [WIN_W-1:0]  eff_base,
   input  logic [WIN_W-1:0]  eff_lim,
   output logic              dec_valid,
   output logic              dec_fwd
);

   localparam int PAGE_W = WIN_W - GRAN_W;

   generate
      if (REQ_W < WIN_W) begin : g_bad_req
         $error("iowin_match: request address narrower than the window");
      end
   endgenerate

   logic              upper_clear;
   logic              in_range;
   logic [WIN_W-1:0]  low_addr;

   assign low_addr = req_addr[WIN_W-1:0];

   // Bits above the 16-bit I/O space
   generate
      if (REQ_W > WIN_W) begin : g_upper
         assign upper_clear = ~|req_addr[REQ_W-1:WIN_W];
         // R8: high address bits block forwarding
         a_r8_high_bits_block : assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && |req_addr[REQ_W-1:WIN_W]) |=> !dec_fwd);
      end else begin : g_no_upper
         assign upper_clear = 1'b1;
      end
   endgenerate

   // Comparator variant chosen by parameter
   generate
      if (FULL_CMP) begin : g_full_cmp
         assign in_range = (low_addr >= eff_base) && (low_addr <= eff_lim);
      end else begin : g_page_cmp
         logic [PAGE_W-1:0] page;
         assign page     = low_addr[WIN_W-1:GRAN_W];
         assign in_range = (page >= cfg_q.base_page) && (page <= cfg_q.lim_page);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_fwd   <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_fwd   <= req_valid && upper_clear && in_range;
      end
   end

   // R9: decision appears exactly one clock after the strobe
   a_r9_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   a_r9_valid_drops : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   a_r9_fwd_qualified : assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_fwd);

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
   import iowin_pkg::*;
#(
   parameter int                    CFG_ADDR_W = 8,
   parameter logic [CFG_ADDR_W-1:0] REG_OFFSET = 8'h1C,
   parameter int                    REQ_W      = 32,
   parameter int                    WIN_W      = 16,
   parameter int                    GRAN_W     = 12,
   parameter bit                    FULL_CMP   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [CFG_ADDR_W-1:0]  cfg_addr,
   input  logic [1:0]             cfg_be,
   input  logic [15:0]            cfg_wdata,
   output logic [15:0]            cfg_rdata,
   input  logic                   req_valid,
   input  logic [REQ_W-1:0]       req_addr,
   output logic                   io_fwd_valid,
   output logic                   io_fwd
);

   localparam int PAGE_W = WIN_W - GRAN_W;

   win_cfg_t          cfg_q;
   logic [WIN_W-1:0]  eff_base;
   logic [WIN_W-1:0]  eff_lim;
   logic              closed;

   iowin_cfg_regs #(
      .CFG_ADDR_W (CFG_ADDR_W),
      .REG_OFFSET (REG_OFFSET),
      .LANES      (2),
      .PAGE_W     (PAGE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cfg_q     (cfg_q)
   );

   iowin_bounds #(
      .WIN_W  (WIN_W),
      .GRAN_W (GRAN_W)
   ) u_bounds (
      .cfg_q    (cfg_q),
      .eff_base (eff_base),
      .eff_lim  (eff_lim),
      .closed   (closed)
   );

   iowin_match #(
      .REQ_W    (REQ_W),
      .WIN_W    (WIN_W),
      .GRAN_W   (GRAN_W),
      .FULL_CMP (FULL_CMP)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .cfg_q     (cfg_q),
      .eff_base  (eff_base),
      .eff_lim   (eff_lim),
      .dec_valid (io_fwd_valid),
      .dec_fwd   (io_fwd)
   );

   // R7: a closed window forwards nothing
   a_r7_closed_window : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && closed) |=> !io_fwd);
   // R6: a forwarded address lies between the padded bounds
   a_r6_fwd_in_bounds : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_addr[WIN_W-1:0] < eff_base) || (req_addr[WIN_W-1:0] > eff_lim)))
      |=> !io_fwd);

endmodule

// File: tb/io_window_decoder_tb.sv
module io_window_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [1:0]  cfg_be = 2'b00;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = 32'h0;
   logic        io_fwd_valid;
   logic        io_fwd;

   int checks = 0;
   int fails  = 0;
   logic [15:0] model = 16'h0;

   always #10 clk = ~clk;   // 50 MHz

   io_window_decoder u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_addr     (cfg_addr),
      .cfg_be       (cfg_be),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .io_fwd_valid (io_fwd_valid),
      .io_fwd       (io_fwd)
   );

   function automatic logic exp_fwd(input logic [15:0] r, input logic [31:0] a);
      logic [15:0] lo;
      logic [15:0] hi;
      lo = {r[7:4], 12'h000};
      hi = {r[15:12], 12'hFFF};
      return (a[31:16] == 16'h0) && (a[15:0] >= lo) && (a[15:0] <= hi);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] off, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = off; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 2'b00;
      if (off[7:1] == 7'h0E) begin
         if (be[0]) model[7:4]   = d[7:4];
         if (be[1]) model[15:12] = d[15:12];
      end
   endtask

   task automatic cfg_read(input string tag, input logic [7:0] off, input logic [15:0] exp);
      cfg_addr = off;
      #1;
      check(tag, {16'h0, cfg_rdata}, {16'h0, exp});
   endtask

   task automatic request(input string tag, input logic [31:0] a);
      logic e;
      @(negedge clk);
      e = exp_fwd(model, a);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " valid"}, {31'h0, io_fwd_valid}, 32'h1);
      check(tag, {31'h0, io_fwd}, {31'h0, e});
   endtask

   task automatic t_reset;
      check("R1 fwd_valid", {31'h0, io_fwd_valid}, 32'h0);
      check("R1 fwd", {31'h0, io_fwd}, 32'h0);
      cfg_read("R1 reg", 8'h1C, 16'h0000);
      request("R6 reset window low", 32'h0000_0000);
      request("R6 reset window top", 32'h0000_0FFF);
      request("R6 reset window above", 32'h0000_1000);
   endtask

   task automatic t_fields;
      cfg_write(8'h1C, 2'b11, 16'hFFFF);
      cfg_read("R5 cap bits", 8'h1C, 16'hF0F0);
      cfg_write(8'h1C, 2'b11, 16'h5030);
      cfg_read("R3 base/limit", 8'h1C, 16'h5030);
      cfg_read("R2 odd offset", 8'h1D, 16'h5030);
      cfg_read("R2 other offset", 8'h18, 16'h0000);
   endtask

   task automatic t_lanes;
      cfg_write(8'h1C, 2'b01, 16'hA0C0);
      cfg_read("R4 lane0 only", 8'h1C, 16'h50C0);
      cfg_write(8'h1C, 2'b10, 16'hE010);
      cfg_read("R4 lane1 only", 8'h1C, 16'hE0C0);
      cfg_write(8'h1C, 2'b00, 16'h1010);
      cfg_read("R4 no lanes", 8'h1C, 16'hE0C0);
   endtask

   task automatic t_offsets;
      cfg_write(8'h20, 2'b11, 16'h3010);
      cfg_read("R2 miss write ignored", 8'h1C, 16'hE0C0);
      cfg_write(8'h1E, 2'b11, 16'h3010);
      cfg_read("R2 neighbour write ignored", 8'h1C, 16'hE0C0);
   endtask

   task automatic t_edges;
      cfg_write(8'h1C, 2'b11, 16'h7020);   // window 2000h..7FFFh
      request("R6 below base", 32'h0000_1FFF);
      request("R6 at base", 32'h0000_2000);
      request("R6 middle", 32'h0000_4567);
      request("R6 at limit", 32'h0000_7FFF);
      request("R6 above limit", 32'h0000_8000);
      cfg_write(8'h1C, 2'b11, 16'h4040);   // single page
      request("R6 single page", 32'h0000_4ABC);
      request("R6 next page", 32'h0000_5000);
   endtask

   task automatic t_closed;
      cfg_write(8'h1C, 2'b11, 16'h3050);   // base 5, limit 3
      request("R7 closed at base", 32'h0000_5000);
      request("R7 closed at limit", 32'h0000_3FFF);
      request("R7 closed between", 32'h0000_4000);
   endtask

   task automatic t_high_bits;
      cfg_write(8'h1C, 2'b11, 16'hF000);   // full 64 KB
      request("R8 in space", 32'h0000_9000);
      request("R8 bit16", 32'h0001_9000);
      request("R8 bit31", 32'h8000_0000);
   endtask

   task automatic t_pipeline;
      // back-to-back requests, then a gap
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_1234;
      @(negedge clk);
      check("R9 first valid", {31'h0, io_fwd_valid}, 32'h1);
      check("R9 first fwd", {31'h0, io_fwd}, 32'h1);
      req_addr = 32'h0002_1234;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 second valid", {31'h0, io_fwd_valid}, 32'h1);
      check("R9 second fwd", {31'h0, io_fwd}, 32'h0);
      @(negedge clk);
      check("R9 idle valid", {31'h0, io_fwd_valid}, 32'h0);
      check("R9 idle fwd", {31'h0, io_fwd}, 32'h0);
      // same-cycle write: request uses the old window (0000h..FFFFh)
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_0100;
      cfg_wr = 1'b1; cfg_addr = 8'h1C; cfg_be = 2'b11; cfg_wdata = 16'h2020;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 2'b00; req_valid = 1'b0;
      model = 16'h2020;
      check("R10 old window used", {31'h0, io_fwd}, 32'h1);
      request("R10 new window used", 32'h0000_0100);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_lanes();
      t_offsets();
      t_edges();
      t_closed();
      t_high_bits();
      t_pipeline();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule